// File: doc/BRIEF.md
# Multiplexed External Memory Bus Sequencer

This block turns single-byte access requests from a processor core into pin-level activity on a multiplexed external memory bus. It runs on a phase clock four times the oscillator rate, so one oscillator period is four phases and one machine cycle is sixteen phases. Strobe edges can therefore sit on quarter-oscillator points. The low address byte and the data byte share one port, and an address-latch-enable pulse marks when the shared port carries the address. The high address byte goes out on a separate port.

Code fetches use a program-store enable and always take one machine cycle. Data reads and writes use their own read and write strobes. A data access lasts from two to nine machine cycles, chosen by a stretch setting. For data accesses that carry only an 8-bit address, the core can ask for the high byte to come from a software-written latch value instead of the request address.

Requests arrive on a valid/ready handshake. `req_valid` must stay high, with all request fields stable, until a clock edge where `req_ready` is also high. The block applies back-pressure by holding `req_ready` low for the whole access and for the completion cycle that follows it. Completion is a plain pulse, `done`, with no back-pressure. `rdata` is meaningful while `done` is high.

Top module: `ebus_seq`

## Requirements
- R1: While `rst_n` is low, `ale` is high and `psen_n`, `rd_n` and `wr_n` are high. After reset and with no request, `ale` is low, `p0_oe` is low, `p2_out` is 8'hFF, `req_ready` is high and `done` is low.
- R2: A request is accepted on a clock edge with `req_valid` and `req_ready` both high, and its phase 0 is the next cycle. `ale` is high for phases 0 to 5, which is 1.5 oscillator periods. `p0_oe` is high and `p0_out` carries `req_addr[7:0]` for phases 0 to 6.
- R3: A fetch (`req_cmd` 2'b00) lasts 16 phases. `psen_n` is low for phases 7 to 15, which is 9 phases or 2.25 oscillator periods. The `p0_in` value present in phase 15 is returned as `rdata`.
- R4: A read (`req_cmd` 2'b01) or a write (`req_cmd` 2'b10) lasts (S+2)×16 phases, where S is `req_stretch` (0 to 7). The read or write strobe is low from phase 16 to phase (S+2)×16−5 inclusive.
- R5: For a read, `rdata` takes the `p0_in` value present in the last phase during which `rd_n` is low.
- R6: For a write, `p0_oe` stays high and `p0_out` carries the write byte from phase 7 to the last phase of the access. The byte is therefore stable before `wr_n` falls and after it rises.
- R7: `psen_n` stays high during data accesses. At most one of `psen_n`, `rd_n` and `wr_n` is low at any time, and none of them is low while `ale` is high.
- R8: `p2_out` carries `req_addr[15:8]` from the accept edge onward, and keeps that value after the access. The exception is a data access with `req_short` high, where `p2_out` carries `req_hi_latch` instead. A fetch ignores `req_short`.
- R9: `done` is high for exactly 16 phases, starting in the phase after the last phase of the access. `req_ready` is low from the accept edge until `done` falls.
- R10: Request fields are captured on the accept edge. Changing them afterwards has no effect on the access in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Phase clock, four times the oscillator rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted on an edge where valid is also high |
| req_cmd | input | 2 | Command: 00 fetch, 01 read, 10 write, 11 treated as read |
| req_addr | input | 16 | Byte address |
| req_short | input | 1 | For data accesses, take the high byte from `req_hi_latch` |
| req_hi_latch | input | 8 | Software-written high-address latch value |
| req_wdata | input | 8 | Write byte |
| req_stretch | input | 3 | Data access length minus two, in machine cycles |
| ale | output | 1 | Address-latch-enable |
| psen_n | output | 1 | Program-store enable, active low |
| rd_n | output | 1 | Data read strobe, active low |
| wr_n | output | 1 | Data write strobe, active low |
| p0_out | output | 8 | Multiplexed port drive value |
| p0_oe | output | 1 | Multiplexed port output enable |
| p0_in | input | 8 | Multiplexed port pin value |
| p2_out | output | 8 | High address byte |
| rdata | output | 8 | Read or fetch result |
| done | output | 1 | Access-complete pulse, one machine cycle long |

## Verification
The assertions assume that `clk` is the 4x phase clock and that request fields hold steady while `req_valid` waits for `req_ready`. They place no condition on `p0_in` outside the sampling phase. The stimulus keeps every request unchanged until its accept edge and then scrambles the fields, so any capture after acceptance shows up on the pins. External memory returns the correct byte only in the intended sampling phase and the inverted byte in every other phase, which exposes an off-by-one in the sample point.

// File: rtl/ebus_pkg.sv
package ebus_pkg;

  typedef enum logic [1:0] {
    CMD_FETCH = 2'b00,
    CMD_READ  = 2'b01,
    CMD_WRITE = 2'b10,
    CMD_RSVD  = 2'b11
  } bus_cmd_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } seq_state_e;

  // The reserved encoding behaves as a data read.
  function automatic bus_cmd_e norm_cmd(input logic [1:0] raw);
    bus_cmd_e c;
    c = bus_cmd_e'(raw);
    if (c == CMD_RSVD) c = CMD_READ;
    return c;
  endfunction

endpackage

// File: rtl/ebus_timer.sv
module ebus_timer
  import ebus_pkg::*;
#(
  parameter int MC_PH     = 16,
  parameter int MIN_MC    = 2,
  parameter int STRETCH_W = 3,
  parameter int CNT_W     = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic                 start_fetch,
  input  logic [STRETCH_W-1:0] start_stretch,
  output seq_state_e           state,
  output logic [CNT_W-1:0]     cnt,
  output logic [CNT_W-1:0]     total
);

  localparam logic [CNT_W-1:0] ONE     = CNT_W'(1);
  localparam logic [CNT_W-1:0] MC_LAST = CNT_W'(MC_PH - 1);

  logic [CNT_W-1:0] data_len;
  assign data_len = CNT_W'((int'(start_stretch) + MIN_MC) * MC_PH);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      cnt   <= '0;
      total <= CNT_W'(MC_PH);
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            state <= ST_RUN;
            cnt   <= '0;
            total <= start_fetch ? CNT_W'(MC_PH) : data_len;
          end
        end
        ST_RUN: begin
          if (cnt == total - ONE) begin
            state <= ST_DONE;
            cnt   <= '0;
          end else begin
            cnt <= cnt + ONE;
          end
        end
        ST_DONE: begin
          if (cnt == MC_LAST) begin
            state <= ST_IDLE;
            cnt   <= '0;
          end else begin
            cnt <= cnt + ONE;
          end
        end
        default: begin
          state <= ST_IDLE;
          cnt   <= '0;
        end
      endcase
    end
  end

endmodule

// File: rtl/ebus_strobes.sv
module ebus_strobes
  import ebus_pkg::*;
#(
  parameter int MC_PH   = 16,
  parameter int ALE_PH  = 6,
  parameter int PSEN_PH = 9,
  parameter int TAIL_PH = 4,
  parameter int CNT_W   = 8
) (
  input  seq_state_e       state,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] total,
  input  bus_cmd_e         cmd,
  output logic             ale_act,
  output logic             psen_act,
  output logic             rd_act,
  output logic             wr_act,
  output logic             addr_phase,
  output logic             drive_en,
  output logic             sample
);

  localparam logic [CNT_W-1:0] ALE_END    = CNT_W'(ALE_PH);
  localparam logic [CNT_W-1:0] ADDR_LAST  = CNT_W'(ALE_PH);
  localparam logic [CNT_W-1:0] PSEN_START = CNT_W'(MC_PH - PSEN_PH);
  localparam logic [CNT_W-1:0] DATA_START = CNT_W'(MC_PH);
  localparam logic [CNT_W-1:0] MC_LAST    = CNT_W'(MC_PH - 1);
  localparam logic [CNT_W-1:0] TAIL       = CNT_W'(TAIL_PH);
  localparam logic [CNT_W-1:0] ONE        = CNT_W'(1);

  logic run, is_fetch, is_write, data_win;
  logic [CNT_W-1:0] data_end;

  assign run      = (state == ST_RUN);
  assign is_fetch = (cmd == CMD_FETCH);
  assign is_write = (cmd == CMD_WRITE);
  assign data_end = total - TAIL;
  assign data_win = run && !is_fetch && (cnt >= DATA_START) && (cnt < data_end);

  always_comb begin
    ale_act    = run && (cnt < ALE_END);
    addr_phase = run && (cnt <= ADDR_LAST);
    psen_act   = run && is_fetch && (cnt >= PSEN_START);
    rd_act     = data_win && !is_write;
    wr_act     = data_win && is_write;
    drive_en   = addr_phase || (run && is_write);
    if (is_fetch) sample = run && (cnt == MC_LAST);
    else          sample = run && !is_write && (cnt == data_end - ONE);
  end

endmodule

// File: rtl/ebus_datapath.sv
module ebus_datapath
  import ebus_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int HI_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  bus_cmd_e          start_cmd,
  input  logic [DATA_W-1:0] start_lo,
  input  logic [HI_W-1:0]   start_hi,
  input  logic              start_short,
  input  logic [HI_W-1:0]   start_latch,
  input  logic [DATA_W-1:0] start_wdata,
  input  logic              addr_phase,
  input  logic              sample,
  input  logic [DATA_W-1:0] bus_in,
  output bus_cmd_e          cmd_q,
  output logic [DATA_W-1:0] bus_out,
  output logic [HI_W-1:0]   hi_out,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] lo_q, wd_q;
  logic              use_latch;

  assign use_latch = start_short && (start_cmd != CMD_FETCH);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q  <= CMD_FETCH;
      lo_q   <= '0;
      wd_q   <= '0;
      hi_out <= '1;
    end else if (start) begin
      cmd_q  <= start_cmd;
      lo_q   <= start_lo;
      wd_q   <= start_wdata;
      hi_out <= use_latch ? start_latch : start_hi;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rdata <= '0;
    else if (sample) rdata <= bus_in;
  end

  assign bus_out = addr_phase ? lo_q : wd_q;

endmodule

// File: rtl/ebus_seq.sv
module ebus_seq
  import ebus_pkg::*;
#(
  parameter int PH_PER_OSC = 4,
  parameter int OSC_PER_MC = 4,
  parameter int ALE_PH     = 6,
  parameter int PSEN_PH    = 9,
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 8,
  parameter int STRETCH_W  = 3,
  parameter int MIN_MC     = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic [1:0]           req_cmd,
  input  logic [ADDR_W-1:0]    req_addr,
  input  logic                 req_short,
  input  logic [ADDR_W-DATA_W-1:0] req_hi_latch,
  input  logic [DATA_W-1:0]    req_wdata,
  input  logic [STRETCH_W-1:0] req_stretch,
  output logic                 ale,
  output logic                 psen_n,
  output logic                 rd_n,
  output logic                 wr_n,
  output logic [DATA_W-1:0]    p0_out,
  output logic                 p0_oe,
  input  logic [DATA_W-1:0]    p0_in,
  output logic [ADDR_W-DATA_W-1:0] p2_out,
  output logic [DATA_W-1:0]    rdata,
  output logic                 done
);

  localparam int MC_PH  = PH_PER_OSC * OSC_PER_MC;
  localparam int MAX_MC = MIN_MC + (1 << STRETCH_W) - 1;
  localparam int CNT_W  = $clog2(MAX_MC * MC_PH + 1);
  localparam int HI_W   = ADDR_W - DATA_W;

  seq_state_e       state;
  logic [CNT_W-1:0] cnt, total;
  bus_cmd_e         cmd_q, cmd_in;
  logic             start;
  logic             ale_act, psen_act, rd_act, wr_act, addr_phase, drive_en, sample;

  assign cmd_in    = norm_cmd(req_cmd);
  assign req_ready = (state == ST_IDLE);
  assign start     = req_valid && req_ready;

  ebus_timer #(
    .MC_PH(MC_PH), .MIN_MC(MIN_MC), .STRETCH_W(STRETCH_W), .CNT_W(CNT_W)
  ) u_timer (
    .clk(clk), .rst_n(rst_n), .start(start),
    .start_fetch(cmd_in == CMD_FETCH), .start_stretch(req_stretch),
    .state(state), .cnt(cnt), .total(total)
  );

  ebus_strobes #(
    .MC_PH(MC_PH), .ALE_PH(ALE_PH), .PSEN_PH(PSEN_PH),
    .TAIL_PH(PH_PER_OSC), .CNT_W(CNT_W)
  ) u_strobes (
    .state(state), .cnt(cnt), .total(total), .cmd(cmd_q),
    .ale_act(ale_act), .psen_act(psen_act), .rd_act(rd_act), .wr_act(wr_act),
    .addr_phase(addr_phase), .drive_en(drive_en), .sample(sample)
  );

  ebus_datapath #(
    .DATA_W(DATA_W), .HI_W(HI_W)
  ) u_data (
    .clk(clk), .rst_n(rst_n), .start(start), .start_cmd(cmd_in),
    .start_lo(req_addr[DATA_W-1:0]), .start_hi(req_addr[ADDR_W-1:DATA_W]),
    .start_short(req_short), .start_latch(req_hi_latch),
    .start_wdata(req_wdata), .addr_phase(addr_phase), .sample(sample),
    .bus_in(p0_in), .cmd_q(cmd_q), .bus_out(p0_out), .hi_out(p2_out),
    .rdata(rdata)
  );

  assign ale    = ale_act | ~rst_n;
  assign psen_n = ~psen_act;
  assign rd_n   = ~rd_act;
  assign wr_n   = ~wr_act;
  assign p0_oe  = drive_en;
  assign done   = (state == ST_DONE);

endmodule

// File: rtl/ebus_seq_chk.sv
module ebus_seq_chk #(
  parameter int PH_PER_OSC = 4,
  parameter int OSC_PER_MC = 4,
  parameter int ALE_PH     = 6,
  parameter int PSEN_PH    = 9,
  parameter int HI_W       = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            ale,
  input logic            psen_n,
  input logic            rd_n,
  input logic            wr_n,
  input logic            p0_oe,
  input logic [HI_W-1:0] p2_out,
  input logic            done,
  input logic            req_ready
);

  localparam int MC_PH = PH_PER_OSC * OSC_PER_MC;
  localparam int CW    = 8;
  localparam logic [CW-1:0] MAXV = '1;

  logic          live;
  logic [CW-1:0] ale_cnt, psen_cnt, done_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live     <= 1'b0;
      ale_cnt  <= '0;
      psen_cnt <= '0;
      done_cnt <= '0;
    end else begin
      live     <= 1'b1;
      ale_cnt  <= !ale    ? '0 : (ale_cnt  == MAXV ? MAXV : ale_cnt  + 1'b1);
      psen_cnt <= psen_n  ? '0 : (psen_cnt == MAXV ? MAXV : psen_cnt + 1'b1);
      done_cnt <= !done   ? '0 : (done_cnt == MAXV ? MAXV : done_cnt + 1'b1);
    end
  end

  // R2: address-latch pulse width
  assert_ale_width_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (live && $fell(ale)) |-> (ale_cnt == CW'(ALE_PH)));

  // R3: program-store strobe width
  assert_psen_width_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (live && $rose(psen_n)) |-> (psen_cnt == CW'(PSEN_PH)));

  // R7: strobes mutually exclusive and never during the address pulse
  assert_one_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({~psen_n, ~rd_n, ~wr_n}) <= 1);
  assert_ale_no_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ale |-> (psen_n && rd_n && wr_n));

  // R6: write data driven while the write strobe is low and just after it rises
  assert_wdata_driven_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_n) |-> p0_oe);
  assert_wdata_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (live && $rose(wr_n)) |-> p0_oe);

  // R8: high address steady during a data strobe
  assert_hi_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (live && !(rd_n && wr_n) && !$past(rd_n && wr_n)) |-> $stable(p2_out));

  // R9: completion pulse length and back-pressure
  assert_done_width_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (live && $fell(done)) |-> (done_cnt == CW'(MC_PH)));
  assert_done_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !req_ready);

endmodule

bind ebus_seq ebus_seq_chk #(
  .PH_PER_OSC(PH_PER_OSC), .OSC_PER_MC(OSC_PER_MC),
  .ALE_PH(ALE_PH), .PSEN_PH(PSEN_PH), .HI_W(ADDR_W - DATA_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .ale(ale), .psen_n(psen_n), .rd_n(rd_n),
  .wr_n(wr_n), .p0_oe(p0_oe), .p2_out(p2_out), .done(done),
  .req_ready(req_ready)
);

// File: tb/test_ebus_seq.sv
module test_ebus_seq;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       req_valid, req_ready, req_short;
  logic [1:0] req_cmd;
  logic [15:0] req_addr;
  logic [7:0] req_hi_latch, req_wdata, p0_out, p0_in, p2_out, rdata;
  logic [2:0] req_stretch;
  logic       ale, psen_n, rd_n, wr_n, p0_oe, done;

  always #10 clk = ~clk;

  ebus_seq i_ebus_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_cmd(req_cmd), .req_addr(req_addr), .req_short(req_short),
    .req_hi_latch(req_hi_latch), .req_wdata(req_wdata),
    .req_stretch(req_stretch), .ale(ale), .psen_n(psen_n), .rd_n(rd_n),
    .wr_n(wr_n), .p0_out(p0_out), .p0_oe(p0_oe), .p0_in(p0_in),
    .p2_out(p2_out), .rdata(rdata), .done(done)
  );

  int vectors = 0;
  int miscompares = 0;
  bit finished = 1'b0;

  task automatic chk(input string rq, input string nm, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s %s at %0t: actual=%0h expected=%0h", rq, nm, $time, act, exp);
    end
  endtask

  function automatic logic [7:0] mem_val(input logic [7:0] hi, input logic [7:0] lo);
    return lo ^ {hi[3:0], hi[7:4]} ^ 8'hA5;
  endfunction

  localparam int NREQ = 10;
  logic [1:0]  t_cmd  [NREQ] = '{2'b00, 2'b01, 2'b10, 2'b01, 2'b00, 2'b10, 2'b01, 2'b00, 2'b10, 2'b01};
  logic [15:0] t_addr [NREQ] = '{16'h1234, 16'hABCD, 16'h5A3C, 16'h9977, 16'h8001,
                                 16'h0042, 16'hFFFF, 16'h0000, 16'h00FF, 16'h2020};
  logic        t_shrt [NREQ] = '{0, 0, 0, 1, 1, 1, 0, 0, 0, 0};
  logic [7:0]  t_lat  [NREQ] = '{8'h00, 8'h00, 8'h00, 8'h3C, 8'h11, 8'hE0, 8'h00, 8'h00, 8'h00, 8'h00};
  logic [7:0]  t_wd   [NREQ] = '{8'h00, 8'h00, 8'hC3, 8'h00, 8'h00, 8'h7E, 8'h00, 8'h00, 8'h00, 8'h00};
  logic [2:0]  t_str  [NREQ] = '{3'd0, 3'd0, 3'd7, 3'd3, 3'd0, 3'd1, 3'd7, 3'd0, 3'd0, 3'd5};
  int          t_gap  [NREQ] = '{2, 0, 3, 1, 0, 5, 0, 4, 0, 2};

  // Behavioural model: mode 0 idle, 1 access, 2 completion
  int mode = 0, t = 0, tot = 16, dt = 0;
  logic [1:0] mcmd = 2'b00;
  logic [7:0] mlo = 0, mhi = 8'hFF, mwd = 0, mrd = 0;

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    int ri, gapc;
    bit drop;
    rst_n = 1'b0; req_valid = 0; req_cmd = 0; req_addr = 0; req_short = 0;
    req_hi_latch = 0; req_wdata = 0; req_stretch = 0; p0_in = 0;
    repeat (3) @(negedge clk);
    // R1: reset values
    chk("R1", "ale in reset", ale, 1);
    chk("R1", "psen_n in reset", psen_n, 1);
    chk("R1", "rd_n in reset", rd_n, 1);
    chk("R1", "wr_n in reset", wr_n, 1);
    chk("R1", "p0_oe in reset", p0_oe, 0);
    rst_n = 1'b1;
    ri = 0; gapc = t_gap[0]; drop = 0;
    while (ri < NREQ || mode != 0 || req_valid) begin
      bit fetch, rd, wr;
      int samp;
      @(negedge clk);
      fetch = (mcmd == 2'b00); rd = (mcmd == 2'b01); wr = (mcmd == 2'b10);
      samp = fetch ? 15 : tot - 5;
      // compare every output against the model
      if (mode == 1) begin
        chk("R2", "ale", ale, t < 6);
        chk("R2/R6", "p0_oe", p0_oe, (t <= 6) || wr);
        if (t <= 6) chk("R2/R10", "p0_out address", p0_out, mlo);
        else if (wr) chk("R6/R10", "p0_out write data", p0_out, mwd);
        chk(fetch ? "R3" : "R7", "psen_n", psen_n, !(fetch && t >= 7));
        chk("R4", "rd_n", rd_n, !(rd && t >= 16 && t < tot - 4));
        chk("R4", "wr_n", wr_n, !(wr && t >= 16 && t < tot - 4));
      end else begin
        chk("R1", "ale idle", ale, 0);
        chk("R1", "p0_oe idle", p0_oe, 0);
        chk("R7", "psen_n idle", psen_n, 1);
        chk("R7", "rd_n idle", rd_n, 1);
        chk("R7", "wr_n idle", wr_n, 1);
      end
      chk("R8/R10", "p2_out", p2_out, mhi);
      chk("R9", "req_ready", req_ready, mode == 0);
      chk("R9", "done", done, mode == 2);
      if (mode == 2 && !wr) chk(fetch ? "R3" : "R5", "rdata", rdata, mrd);

      // stimulus: R10 scrambles fields once accepted
      if (drop) begin
        drop = 0; req_valid = 0;
        req_cmd = 2'b10; req_addr = 16'h6E6E; req_short = 1;
        req_hi_latch = 8'h99; req_wdata = 8'h5F; req_stretch = 3'd6;
      end
      if (ri < NREQ && !req_valid) begin
        if (gapc == 0) begin
          req_valid = 1; req_cmd = t_cmd[ri]; req_addr = t_addr[ri];
          req_short = t_shrt[ri]; req_hi_latch = t_lat[ri];
          req_wdata = t_wd[ri]; req_stretch = t_str[ri];
        end else gapc--;
      end
      // external memory: correct byte only in the sampling phase
      if (mode == 1) p0_in = (t == samp) ? mem_val(mhi, mlo) : ~mem_val(mhi, mlo);
      else p0_in = 8'h00;

      // advance model past the coming edge
      if (mode == 0) begin
        if (req_valid) begin
          mcmd = req_cmd; mlo = req_addr[7:0]; mwd = req_wdata;
          mhi = (req_short && req_cmd != 2'b00) ? req_hi_latch : req_addr[15:8];
          tot = (req_cmd == 2'b00) ? 16 : (int'(req_stretch) + 2) * 16;
          mrd = mem_val(mhi, mlo);
          mode = 1; t = 0; drop = 1;
          ri++; gapc = (ri < NREQ) ? t_gap[ri] : 0;
        end
      end else if (mode == 1) begin
        if (t == tot - 1) begin mode = 2; dt = 0; end
        else t++;
      end else begin
        if (dt == 15) mode = 0;
        else dt++;
      end
    end
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule